// File: doc/BRIEF.md
# Reconfigurable Bit-Line Logic Sense Array

This block models a column-parallel memory sub-array whose sense stage can be reprogrammed. It can read one row, or it can combine two or three rows that share each bit-line. A vector of reference enables selects the operation, not an opcode. One enable alone gives a single-threshold function. Two or three enables together give XOR2 or a full add, which returns sum and carry in one sensing cycle. Every result is given in true and complement form on every column. The analog sensing is replaced by direct logic on the stored bits.

A sense is requested with a strobe, and its result is registered at that clock edge. Some strobes carry an enable combination that is not in the configuration set. Others carry a row count that does not match the operation, or name the same row twice. These strobes are rejected: they raise an error flag and leave the outputs unchanged. A separate write port stores a data vector into any row, so results can be written back for bit-serial arithmetic.

Top module: `bitLineSenseArray`

## Requirements
- R1: After reset, outTrue is all zeros, outComp is all ones, carryOut is zero, errFlag is zero, and every row of the array reads as zero.
- R2: Read is refEn=6'b000001 with rowCount=1 and returns row rowSelA. The refEn bits are: bit0 memory reference, bit1 OR2, bit2 AND2, bit3 MAJ, bit4 OR3, bit5 AND3.
- R3: refEn=6'b000010 with rowCount=2 gives rowA OR rowB. refEn=6'b000100 with rowCount=2 gives rowA AND rowB.
- R4: refEn=6'b000110, which sets OR2 and AND2 together, with rowCount=2 gives rowA XOR rowB.
- R5: refEn=6'b001000 with rowCount=3 gives the bitwise majority of rows A, B and C.
- R6: refEn=6'b010000 with rowCount=3 gives the three-row OR. refEn=6'b100000 with rowCount=3 gives the three-row AND.
- R7: refEn=6'b111000 with rowCount=3 is a full add. outTrue is the sum, which is the inverted majority except that it is forced to 0 for inputs 0,0,0 and to 1 for inputs 1,1,1. carryOut is the majority.
- R8: outComp is always the bitwise inverse of outTrue.
- R9: A strobe whose refEn is not one of the eight listed codes sets errFlag. outTrue, outComp and carryOut keep their previous values.
- R10: A strobe is also rejected as in R9 when rowCount differs from the row count the operation needs (0 is never valid, 3 is the maximum), or when the rows in use name the same row twice.
- R11: A result appears on the outputs right after the clock edge at which senseStrobe is high. Without a strobe all outputs hold. A legal strobe clears errFlag.
- R12: When wrEn is high, wrData is stored into row wrRow at that edge. This happens whether or not a strobe is legal. A sense in the same cycle sees the contents from before the write.
- R13: After any legal operation other than the full add, carryOut is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| senseStrobe | input | 1 | Starts a sense operation this cycle |
| refEn | input | 6 | Reference-enable vector that selects the operation |
| rowCount | input | 2 | Number of rows in use (A, A+B, A+B+C) |
| rowSelA | input | ROW_AW | First selected row |
| rowSelB | input | ROW_AW | Second selected row |
| rowSelC | input | ROW_AW | Third selected row |
| wrEn | input | 1 | Write enable |
| wrRow | input | ROW_AW | Row to write |
| wrData | input | NUM_COLS | Data to write |
| outTrue | output | NUM_COLS | Registered result per column |
| outComp | output | NUM_COLS | Registered complement per column |
| carryOut | output | NUM_COLS | Registered carry per column (full add only) |
| errFlag | output | 1 | Last strobe was rejected |

## Verification
A sense and a write can fall in the same cycle, and they can target the same row. The bench writes new data into row A while it strobes a sense of that row. The result must show the old data. A later sense of the row must show the new data. The bench also combines a write with a rejected strobe, to check that the write still lands while errFlag rises and the outputs hold.

// File: rtl/bitsense_pkg.sv
package bitsense_pkg;
  localparam int EN_W    = 6;
  localparam int EN_MEM  = 0;
  localparam int EN_OR2  = 1;
  localparam int EN_AND2 = 2;
  localparam int EN_MAJ  = 3;
  localparam int EN_OR3  = 4;
  localparam int EN_AND3 = 5;

  typedef enum logic [2:0] {
    OP_READ, OP_OR2, OP_AND2, OP_XOR2, OP_MAJ, OP_OR3, OP_AND3, OP_ADD
  } senseOp_e;

  typedef struct packed {
    logic     capture;
    logic     reject;
    senseOp_e op;
  } senseCmd_t;
endpackage

// File: rtl/senseCtrl.sv
module senseCtrl
  import bitsense_pkg::*;
#(
  parameter int ROW_AW = 4
) (
  input  logic                senseStrobe,
  input  logic [EN_W-1:0]     refEn,
  input  logic [1:0]          rowCount,
  input  logic [ROW_AW-1:0]   rowSelA,
  input  logic [ROW_AW-1:0]   rowSelB,
  input  logic [ROW_AW-1:0]   rowSelC,
  output senseCmd_t           cmd
);
  senseOp_e opSel;
  logic [1:0] needRows;
  logic known;
  logic dupRow;
  logic legal;

  always_comb begin
    opSel    = OP_READ;
    needRows = 2'd1;
    known    = 1'b1;
    unique case (refEn)
      6'b000001: begin opSel = OP_READ; needRows = 2'd1; end
      6'b000010: begin opSel = OP_OR2;  needRows = 2'd2; end
      6'b000100: begin opSel = OP_AND2; needRows = 2'd2; end
      6'b000110: begin opSel = OP_XOR2; needRows = 2'd2; end
      6'b001000: begin opSel = OP_MAJ;  needRows = 2'd3; end
      6'b010000: begin opSel = OP_OR3;  needRows = 2'd3; end
      6'b100000: begin opSel = OP_AND3; needRows = 2'd3; end
      6'b111000: begin opSel = OP_ADD;  needRows = 2'd3; end
      default:   known = 1'b0;
    endcase
  end

  always_comb begin
    dupRow = 1'b0;
    if (needRows >= 2'd2 && rowSelA == rowSelB) dupRow = 1'b1;
    if (needRows == 2'd3 && (rowSelA == rowSelC || rowSelB == rowSelC)) dupRow = 1'b1;
  end

  assign legal       = known && (rowCount == needRows) && !dupRow;
  assign cmd.capture = senseStrobe && legal;
  assign cmd.reject  = senseStrobe && !legal;
  assign cmd.op      = opSel;
endmodule

// File: rtl/senseDatapath.sv
module senseDatapath
  import bitsense_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int NUM_ROWS = 16,
  localparam int ROW_AW  = $clog2(NUM_ROWS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  senseCmd_t           cmd,
  input  logic [ROW_AW-1:0]   rowSelA,
  input  logic [ROW_AW-1:0]   rowSelB,
  input  logic [ROW_AW-1:0]   rowSelC,
  input  logic                wrEn,
  input  logic [ROW_AW-1:0]   wrRow,
  input  logic [NUM_COLS-1:0] wrData,
  output logic [NUM_COLS-1:0] outTrue,
  output logic [NUM_COLS-1:0] outComp,
  output logic [NUM_COLS-1:0] carryOut,
  output logic                errFlag
);
  logic [NUM_COLS-1:0] cellRows [NUM_ROWS];
  logic [NUM_COLS-1:0] bitA, bitB, bitC;
  logic [NUM_COLS-1:0] colRes, colCarry;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_ROWS; r++) cellRows[r] <= '0;
    end else if (wrEn) begin
      cellRows[wrRow] <= wrData;
    end
  end

  assign bitA = cellRows[rowSelA];
  assign bitB = cellRows[rowSelB];
  assign bitC = cellRows[rowSelC];

  for (genvar col = 0; col < NUM_COLS; col++) begin : g_col
    logic a, b, c, majV, sumV;
    assign a    = bitA[col];
    assign b    = bitB[col];
    assign c    = bitC[col];
    assign majV = (a & b) | (a & c) | (b & c);
    // inverted majority, corrected at the two extreme patterns
    always_comb begin
      if (a & b & c)          sumV = 1'b1;
      else if (!(a | b | c))  sumV = 1'b0;
      else                    sumV = ~majV;
    end
    always_comb begin
      colCarry[col] = 1'b0;
      unique case (cmd.op)
        OP_READ: colRes[col] = a;
        OP_OR2:  colRes[col] = a | b;
        OP_AND2: colRes[col] = a & b;
        OP_XOR2: colRes[col] = (a | b) & ~(a & b);
        OP_MAJ:  colRes[col] = majV;
        OP_OR3:  colRes[col] = a | b | c;
        OP_AND3: colRes[col] = a & b & c;
        OP_ADD: begin
          colRes[col]   = sumV;
          colCarry[col] = majV;
        end
        default: colRes[col] = a;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outTrue  <= '0;
      outComp  <= '1;
      carryOut <= '0;
      errFlag  <= 1'b0;
    end else if (cmd.capture) begin
      outTrue  <= colRes;
      outComp  <= ~colRes;
      carryOut <= colCarry;
      errFlag  <= 1'b0;
    end else if (cmd.reject) begin
      errFlag  <= 1'b1;
    end
  end
endmodule

// File: rtl/bitLineSenseArray.sv
module bitLineSenseArray
  import bitsense_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int NUM_ROWS = 16,
  localparam int ROW_AW  = $clog2(NUM_ROWS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                senseStrobe,
  input  logic [5:0]          refEn,
  input  logic [1:0]          rowCount,
  input  logic [ROW_AW-1:0]   rowSelA,
  input  logic [ROW_AW-1:0]   rowSelB,
  input  logic [ROW_AW-1:0]   rowSelC,
  input  logic                wrEn,
  input  logic [ROW_AW-1:0]   wrRow,
  input  logic [NUM_COLS-1:0] wrData,
  output logic [NUM_COLS-1:0] outTrue,
  output logic [NUM_COLS-1:0] outComp,
  output logic [NUM_COLS-1:0] carryOut,
  output logic                errFlag
);
  senseCmd_t cmd;

  senseCtrl #(.ROW_AW(ROW_AW)) ctrlInst (
    .senseStrobe(senseStrobe), .refEn(refEn), .rowCount(rowCount),
    .rowSelA(rowSelA), .rowSelB(rowSelB), .rowSelC(rowSelC), .cmd(cmd)
  );

  senseDatapath #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) dpInst (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .rowSelA(rowSelA), .rowSelB(rowSelB), .rowSelC(rowSelC),
    .wrEn(wrEn), .wrRow(wrRow), .wrData(wrData),
    .outTrue(outTrue), .outComp(outComp), .carryOut(carryOut), .errFlag(errFlag)
  );
endmodule

// File: rtl/bitLineSenseArray_chk.sv
module bitLineSenseArray_chk #(
  parameter int NUM_COLS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                senseStrobe,
  input logic [5:0]          refEn,
  input logic [NUM_COLS-1:0] outTrue,
  input logic [NUM_COLS-1:0] outComp,
  input logic [NUM_COLS-1:0] carryOut,
  input logic                errFlag
);
  // R8
  complement_chk: assert property (@(posedge clk) disable iff (!rstN)
    outComp == ~outTrue);

  // R9
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> ($stable(outTrue) && $stable(carryOut)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !senseStrobe |=> ($stable(outTrue) && $stable(carryOut) && $stable(errFlag)));

  // R13
  carry_non_add_chk: assert property (@(posedge clk) disable iff (!rstN)
    (senseStrobe && refEn != 6'b111000) |=> ((carryOut == '0) || errFlag));
endmodule

bind bitLineSenseArray bitLineSenseArray_chk #(.NUM_COLS(NUM_COLS)) chkInst (
  .clk(clk), .rstN(rstN), .senseStrobe(senseStrobe), .refEn(refEn),
  .outTrue(outTrue), .outComp(outComp), .carryOut(carryOut), .errFlag(errFlag)
);

// File: tb/tb_bitLineSenseArray.sv
module tb_bitLineSenseArray;
  localparam int CLK_PERIOD = 10;
  localparam int COLS = 8;
  localparam int ROWS = 16;
  localparam int AW = $clog2(ROWS);

  typedef struct packed {
    logic [COLS-1:0] t;
    logic [COLS-1:0] c;
    logic [COLS-1:0] cy;
    logic            err;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic senseStrobe = 1'b0;
  logic [5:0] refEn = '0;
  logic [1:0] rowCount = '0;
  logic [AW-1:0] rowSelA = '0, rowSelB = '0, rowSelC = '0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrRow = '0;
  logic [COLS-1:0] wrData = '0;
  logic [COLS-1:0] outTrue, outComp, carryOut;
  logic errFlag;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  expItem_t expQ[$];
  string tagQ[$];
  logic [COLS-1:0] model [ROWS];
  expItem_t lastExp;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitLineSenseArray #(.NUM_COLS(COLS), .NUM_ROWS(ROWS)) dut (
    .clk(clk), .rstN(rstN), .senseStrobe(senseStrobe), .refEn(refEn),
    .rowCount(rowCount), .rowSelA(rowSelA), .rowSelB(rowSelB), .rowSelC(rowSelC),
    .wrEn(wrEn), .wrRow(wrRow), .wrData(wrData),
    .outTrue(outTrue), .outComp(outComp), .carryOut(carryOut), .errFlag(errFlag)
  );

  // monitor
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      string tg;
      e = expQ.pop_front();
      tg = tagQ.pop_front();
      checks++;
      if (outTrue !== e.t || outComp !== e.c || carryOut !== e.cy || errFlag !== e.err) begin
        failures++;
        $display("FAIL %s: actual t=%h c=%h cy=%h err=%b expected t=%h c=%h cy=%h err=%b",
                 tg, outTrue, outComp, carryOut, errFlag, e.t, e.c, e.cy, e.err);
      end
    end
  end

  function automatic expItem_t evalOp(input logic [5:0] en, input logic [COLS-1:0] a,
                                      input logic [COLS-1:0] b, input logic [COLS-1:0] c);
    expItem_t r;
    logic [COLS-1:0] m;
    m = (a & b) | (a & c) | (b & c);
    r.cy = '0;
    r.err = 1'b0;
    case (en)
      6'b000001: r.t = a;
      6'b000010: r.t = a | b;
      6'b000100: r.t = a & b;
      6'b000110: r.t = a ^ b;
      6'b001000: r.t = m;
      6'b010000: r.t = a | b | c;
      6'b100000: r.t = a & b & c;
      default: begin r.t = a ^ b ^ c; r.cy = m; end
    endcase
    r.c = ~r.t;
    return r;
  endfunction

  task automatic senseOp(input logic [5:0] en, input logic [1:0] cnt,
                         input int ra, input int rb, input int rc,
                         input bit illegal, input string tg,
                         input bit doWr = 0, input int wr = 0,
                         input logic [COLS-1:0] wd = '0);
    expItem_t e;
    @(negedge clk);
    senseStrobe = 1'b1; refEn = en; rowCount = cnt;
    rowSelA = AW'(ra); rowSelB = AW'(rb); rowSelC = AW'(rc);
    wrEn = doWr; wrRow = AW'(wr); wrData = wd;
    if (illegal) begin
      e = lastExp;
      e.err = 1'b1;
    end else begin
      e = evalOp(en, model[ra], model[rb], model[rc]);
    end
    @(posedge clk);
    #1;
    if (doWr) model[wr] = wd;
    senseStrobe = 1'b0; wrEn = 1'b0;
    lastExp = e;
    expQ.push_back(e);
    tagQ.push_back(tg);
  endtask

  task automatic writeRow(input int r, input logic [COLS-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrRow = AW'(r); wrData = d;
    @(posedge clk);
    #1;
    model[r] = d;
    wrEn = 1'b0;
  endtask

  task automatic idleCheck(input string tg);
    @(negedge clk);
    @(posedge clk);
    #1;
    expQ.push_back(lastExp);
    tagQ.push_back(tg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < ROWS; r++) model[r] = '0;
    lastExp = '{t: '0, c: '1, cy: '0, err: 1'b0};
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    expQ.push_back(lastExp); tagQ.push_back("R1 reset outputs");
    senseOp(6'b000001, 2'd1, 7, 0, 0, 0, "R1 reset memory zero");

    writeRow(1, 8'hF0);
    writeRow(2, 8'hCC);
    writeRow(3, 8'hAA);
    writeRow(4, 8'h00);
    writeRow(5, 8'hFF);

    senseOp(6'b000001, 2'd1, 2, 0, 0, 0, "R2 read row2");
    senseOp(6'b000010, 2'd2, 1, 3, 0, 0, "R3 OR2");
    senseOp(6'b000100, 2'd2, 1, 3, 0, 0, "R3 AND2");
    senseOp(6'b000110, 2'd2, 2, 3, 0, 0, "R4 XOR2");
    senseOp(6'b001000, 2'd3, 1, 2, 3, 0, "R5 MAJ");
    senseOp(6'b010000, 2'd3, 1, 2, 3, 0, "R6 OR3");
    senseOp(6'b100000, 2'd3, 1, 2, 3, 0, "R6 AND3");
    senseOp(6'b111000, 2'd3, 1, 2, 3, 0, "R7 full add all patterns");
    idleCheck("R11 hold without strobe");
    senseOp(6'b111000, 2'd3, 4, 6, 7, 0, "R7 add 000 gives sum0");
    senseOp(6'b111000, 2'd3, 5, 1, 2, 0, "R7 add mixed");
    writeRow(6, 8'hFF);
    writeRow(7, 8'hFF);
    senseOp(6'b111000, 2'd3, 5, 6, 7, 0, "R7 add 111 gives sum1 carry1");
    senseOp(6'b000010, 2'd2, 1, 2, 0, 0, "R13 carry cleared after OR2");
    senseOp(6'b111000, 2'd3, 1, 2, 3, 0, "R7 add before reject");
    senseOp(6'b000011, 2'd2, 1, 2, 0, 1, "R9 unlisted enables held");
    idleCheck("R11 errFlag held");
    senseOp(6'b001000, 2'd3, 1, 1, 3, 1, "R10 duplicate row");
    senseOp(6'b000100, 2'd2, 1, 2, 2, 0, "R10 third row ignored in 2-row op");
    senseOp(6'b000001, 2'd2, 1, 0, 0, 1, "R10 rowCount mismatch");
    senseOp(6'b000001, 2'd0, 1, 0, 0, 1, "R10 rowCount zero");
    senseOp(6'b000000, 2'd1, 1, 0, 0, 1, "R9 no enables");
    senseOp(6'b000001, 2'd1, 3, 0, 0, 0, "R11 legal strobe clears flag");
    // R12 write and sense same row same cycle: old data seen
    senseOp(6'b000001, 2'd1, 3, 0, 0, 0, "R12 sense sees old data", 1, 3, 8'h5A);
    senseOp(6'b000001, 2'd1, 3, 0, 0, 0, "R12 write landed");
    // R12 write lands during rejected strobe
    senseOp(6'b010001, 2'd1, 3, 0, 0, 1, "R12 write with reject", 1, 8, 8'h3C);
    senseOp(6'b000001, 2'd1, 8, 0, 0, 0, "R12 write during reject landed");
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule